// File: doc/BRIEF.md
# Two-Line Fully Associative Data Cache Controller

This block is a very small data cache placed between a processor request port and a byte-wide backing memory. It holds a few short blocks. Every address is compared against all resident blocks at once, so any block can sit in any line. When a request misses, the least recently used line is refilled with the whole block from memory. The controller then finishes the load or store against the refilled line.

A processor request is a one-cycle pulse on `cpu_req` while `cpu_ready` is high. It carries a load/store flag, an address and store data. The controller lowers `cpu_ready` while it works and pulses `cpu_done` for one cycle when the access is complete. For a load, `cpu_rdata` holds the byte from that cycle on. On the memory side, each byte transfer is a request that is held until memory acknowledges it.

The write policy is fixed at build time by a parameter. Write-back mode keeps a dirty flag per line and writes a line back only when it is evicted while dirty. Write-through mode sends every store to memory, including stores that hit. In both modes a store that misses first allocates the line. Hit and miss counters record the outcome of every processor access.

Top module: `assoc_cache_ctl`

## Requirements
- R1: After reset `cpu_ready` is 1, `mem_req` is 0, both counters are 0 and no line is valid.
- R2: A load that misses issues two memory reads, at block offset 0 then offset 1 (address = {tag, offset}, offset in bit 0), and returns the addressed byte.
- R3: An access to a byte of a resident block hits, causes no memory traffic and returns the cached byte.
- R4: On a miss with all lines valid, the victim is the least recently used line; both loads and stores make the accessed line most recent, and invalid lines are filled before any valid line is evicted.
- R5: Blocks whose tags differ in any bits can be resident at the same time; placement does not depend on the address.
- R6: In write-back mode (WRITE_BACK=1) a store hit updates only the cache: memory is unchanged and there is no memory traffic.
- R7: In write-back mode, evicting a dirty line first writes both of its bytes to memory, offset 0 then 1, and only then reads the new block. Evicting a clean line causes no memory write.
- R8: A store miss allocates: the block is read from memory, the stored byte then replaces the addressed byte in the line, and later loads of that block hit.
- R9: In write-through mode (WRITE_BACK=0) every store writes its byte to memory at its own address after any fill, hit or miss. Evictions never write to memory.
- R10: `cpu_ready` is low from the cycle after a request is accepted until the cycle `cpu_done` is raised. `cpu_done` lasts exactly one cycle.
- R11: Each access adds exactly one to either the hit counter or the miss counter. A refill followed by completion counts only as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request pulse, taken when cpu_ready is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store byte |
| cpu_ready | output | 1 | Controller idle and able to accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result, valid from cpu_done |
| mem_req | output | 1 | Memory transfer request, held until mem_ack |
| mem_we | output | 1 | 1 = write transfer, 0 = read transfer |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Byte to write |
| mem_ack | input | 1 | Memory acknowledges the current transfer |
| mem_rdata | input | DATA_W | Read byte, valid with mem_ack |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |

## Verification
The hardest case to reach is an eviction of a dirty line that was chosen only because a later store, not a load, changed the recency order. This case also shows whether the writeback finishes before the fill starts. To reach it, the stimulus first makes both lines dirty with store hits. Each store to the second line makes it most recent, so the first dirty line becomes the victim. A miss then follows, and the memory model logs every transfer in order. The expected log is two writes carrying the victim's cached bytes, then two reads of the new block. A second instance built for write-through is driven through hits, misses and evictions. Its log must contain exactly one write per store and no writes caused by evictions.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOKUP,
    S_EVICT,
    S_FILL,
    S_WTHRU
  } cstate_t;
endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int LINES = 2,
  parameter int TAG_W = 3,
  parameter int IDX_W = 1
) (
  input  logic [LINES-1:0]       valid,
  input  logic [LINES*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]       req_tag,
  output logic                   hit,
  output logic [IDX_W-1:0]       hit_idx
);
  logic [LINES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_cmp
      assign match[g] = valid[g] && (tags[g*TAG_W +: TAG_W] == req_tag);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int LINES = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [LINES-1:0] valid,
  output logic [IDX_W-1:0] victim_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(LINES - 1);

  logic [IDX_W-1:0] age [LINES];
  logic [IDX_W-1:0] touched_age;

  always_comb begin
    touched_age = '0;
    for (int i = 0; i < LINES; i++) begin
      if (IDX_W'(i) == touch_idx) touched_age = age[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_age
      always_ff @(posedge clk) begin
        if (rst) begin
          age[g] <= IDX_W'(LINES - 1 - g);
        end else if (touch) begin
          if (IDX_W'(g) == touch_idx) age[g] <= '0;
          else if (age[g] < touched_age) age[g] <= age[g] + IDX_W'(1);
        end
      end
    end
  endgenerate

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (age[i] == OLDEST) victim_idx = IDX_W'(i);
    end
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
    if (found) victim_idx = victim_idx;
  end
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int LINES  = 2,
  parameter int IDX_W  = 1,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_line,
  input  logic [OFF_W-1:0]  w_off,
  input  logic [DATA_W-1:0] w_data,
  input  logic [IDX_W-1:0]  a_line,
  input  logic [OFF_W-1:0]  a_off,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_line,
  input  logic [OFF_W-1:0]  b_off,
  output logic [DATA_W-1:0] b_data
);
  localparam int DEPTH = LINES << OFF_W;
  localparam int AW    = IDX_W + OFF_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[AW'({w_line, w_off})] <= w_data;
  end

  assign a_data = mem[AW'({a_line, a_off})];
  assign b_data = mem[AW'({b_line, b_off})];
endmodule

// File: rtl/assoc_cache_ctl.sv
module assoc_cache_ctl
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int LINES       = 2,
  parameter int BLOCK_BYTES = 2,
  parameter int CNT_W       = 16,
  parameter bit WRITE_BACK  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(BLOCK_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  cstate_t state;

  logic              req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              refilled;
  logic [OFF_W-1:0]  beat;
  logic [IDX_W-1:0]  vict;

  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [LINES*TAG_W-1:0] tags_flat;

  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  victim_idx;
  logic              lru_touch;

  logic              d_we;
  logic [IDX_W-1:0]  d_line;
  logic [OFF_W-1:0]  d_off;
  logic [DATA_W-1:0] d_wdata;
  logic [DATA_W-1:0] hit_byte;
  logic [DATA_W-1:0] vict_byte;

  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  logic [CNT_W-1:0]  hit_q;
  logic [CNT_W-1:0]  miss_q;

  assign req_tag = req_addr[ADDR_W-1:OFF_W];
  assign req_off = req_addr[OFF_W-1:0];

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_flat
      assign tags_flat[g*TAG_W +: TAG_W] = tag_q[g];
    end
  endgenerate

  cache_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .valid   (valid_q),
    .tags    (tags_flat),
    .req_tag (req_tag),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  assign lru_touch = (state == S_LOOKUP) && hit;

  cache_lru #(.LINES(LINES), .IDX_W(IDX_W)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch      (lru_touch),
    .touch_idx  (hit_idx),
    .valid      (valid_q),
    .victim_idx (victim_idx)
  );

  always_comb begin
    d_we    = 1'b0;
    d_line  = hit_idx;
    d_off   = req_off;
    d_wdata = req_wdata;
    if (state == S_LOOKUP && hit && req_we) begin
      d_we = 1'b1;
    end else if (state == S_FILL && mem_ack) begin
      d_we    = 1'b1;
      d_line  = vict;
      d_off   = beat;
      d_wdata = mem_rdata;
    end
  end

  cache_data_store #(
    .LINES(LINES), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) u_data (
    .clk    (clk),
    .we     (d_we),
    .w_line (d_line),
    .w_off  (d_off),
    .w_data (d_wdata),
    .a_line (hit_idx),
    .a_off  (req_off),
    .a_data (hit_byte),
    .b_line (vict),
    .b_off  (beat),
    .b_data (vict_byte)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = req_addr;
    mem_wdata = req_wdata;
    unique case (state)
      S_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {tag_q[vict], beat};
        mem_wdata = vict_byte;
      end
      S_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {req_tag, beat};
      end
      S_WTHRU: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      refilled  <= 1'b0;
      beat      <= '0;
      vict      <= '0;
      valid_q   <= '0;
      dirty_q   <= '0;
      done_q    <= 1'b0;
      rdata_q   <= '0;
      hit_q     <= '0;
      miss_q    <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cpu_req) begin
            req_we    <= cpu_we;
            req_addr  <= cpu_addr;
            req_wdata <= cpu_wdata;
            refilled  <= 1'b0;
            state     <= S_LOOKUP;
          end
        end
        S_LOOKUP: begin
          if (hit) begin
            if (!refilled) hit_q <= hit_q + CNT_ONE;
            if (req_we) begin
              if (WRITE_BACK) begin
                dirty_q[hit_idx] <= 1'b1;
                done_q           <= 1'b1;
                state            <= S_IDLE;
              end else begin
                state <= S_WTHRU;
              end
            end else begin
              rdata_q <= hit_byte;
              done_q  <= 1'b1;
              state   <= S_IDLE;
            end
          end else begin
            miss_q              <= miss_q + CNT_ONE;
            vict                <= victim_idx;
            beat                <= '0;
            valid_q[victim_idx] <= 1'b0;
            if (WRITE_BACK && valid_q[victim_idx] && dirty_q[victim_idx])
              state <= S_EVICT;
            else
              state <= S_FILL;
          end
        end
        S_EVICT: begin
          if (mem_ack) begin
            beat <= beat + OFF_W'(1);
            if (beat == LAST_BEAT) begin
              beat  <= '0;
              state <= S_FILL;
            end
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            beat <= beat + OFF_W'(1);
            if (beat == LAST_BEAT) begin
              tag_q[vict]   <= req_tag;
              valid_q[vict] <= 1'b1;
              dirty_q[vict] <= 1'b0;
              refilled      <= 1'b1;
              state         <= S_LOOKUP;
            end
          end
        end
        S_WTHRU: begin
          if (mem_ack) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cpu_ready  = (state == S_IDLE);
  assign cpu_done   = done_q;
  assign cpu_rdata  = rdata_q;
  assign hit_count  = hit_q;
  assign miss_count = miss_q;
endmodule

// File: rtl/assoc_cache_ctl_chk.sv
module assoc_cache_ctl_chk #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !mem_req);

  p_req_held_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> cpu_ready);

  p_one_count_r11: assert property (@(posedge clk) disable iff (rst)
    !($stable(hit_count)) |-> $stable(miss_count));
endmodule

bind assoc_cache_ctl assoc_cache_ctl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_ready  (cpu_ready),
  .cpu_done   (cpu_done),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .hit_count  (hit_count),
  .miss_count (miss_count)
);

// File: tb/sim_mem.sv
module sim_mem (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       we,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic       ack,
  output logic [7:0] rdata
);
  logic [7:0]  mem   [16];
  logic [12:0] log_e [64];
  int          log_n;

  always @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= '0;
      log_n <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= 8'(8'h20 + 8'h11 * i);
    end else if (req && !ack) begin
      ack <= 1'b1;
      if (we) begin
        mem[addr] <= wdata;
        if (log_n < 64) log_e[log_n] <= {1'b1, addr, wdata};
      end else begin
        rdata <= mem[addr];
        if (log_n < 64) log_e[log_n] <= {1'b0, addr, mem[addr]};
      end
      log_n <= log_n + 1;
    end else begin
      ack <= 1'b0;
    end
  end
endmodule

// File: tb/sim_assoc_cache_ctl.sv
`timescale 1ns/1ps
module sim_assoc_cache_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       cpu_req   [2];
  logic       cpu_we    [2];
  logic [3:0] cpu_addr  [2];
  logic [7:0] cpu_wdata [2];
  logic       cpu_ready [2];
  logic       cpu_done  [2];
  logic [7:0] cpu_rdata [2];
  logic       mem_req   [2];
  logic       mem_we    [2];
  logic [3:0] mem_addr  [2];
  logic [7:0] mem_wdata [2];
  logic       mem_ack   [2];
  logic [7:0] mem_rdata [2];
  logic [15:0] hits     [2];
  logic [15:0] misses   [2];

  int n_chk  = 0;
  int n_fail = 0;
  int last_start = 0;
  bit finished = 1'b0;

  assoc_cache_ctl #(.WRITE_BACK(1'b1)) u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]),
    .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]), .cpu_ready(cpu_ready[0]),
    .cpu_done(cpu_done[0]), .cpu_rdata(cpu_rdata[0]), .mem_req(mem_req[0]),
    .mem_we(mem_we[0]), .mem_addr(mem_addr[0]), .mem_wdata(mem_wdata[0]),
    .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0]), .hit_count(hits[0]),
    .miss_count(misses[0]));

  assoc_cache_ctl #(.WRITE_BACK(1'b0)) u1 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]),
    .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]), .cpu_ready(cpu_ready[1]),
    .cpu_done(cpu_done[1]), .cpu_rdata(cpu_rdata[1]), .mem_req(mem_req[1]),
    .mem_we(mem_we[1]), .mem_addr(mem_addr[1]), .mem_wdata(mem_wdata[1]),
    .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1]), .hit_count(hits[1]),
    .miss_count(misses[1]));

  sim_mem u_m0 (.clk(clk), .rst(rst), .req(mem_req[0]), .we(mem_we[0]),
    .addr(mem_addr[0]), .wdata(mem_wdata[0]), .ack(mem_ack[0]), .rdata(mem_rdata[0]));
  sim_mem u_m1 (.clk(clk), .rst(rst), .req(mem_req[1]), .we(mem_we[1]),
    .addr(mem_addr[1]), .wdata(mem_wdata[1]), .ack(mem_ack[1]), .rdata(mem_rdata[1]));

  function automatic logic [7:0] ib(int i);
    return 8'(8'h20 + 8'h11 * i);
  endfunction

  function automatic int log_len(int sel);
    return (sel == 0) ? u_m0.log_n : u_m1.log_n;
  endfunction

  function automatic logic [12:0] log_at(int sel, int k);
    return (sel == 0) ? u_m0.log_e[k] : u_m1.log_e[k];
  endfunction

  function automatic logic [7:0] mem_at(int sel, int a);
    return (sel == 0) ? u_m0.mem[a] : u_m1.mem[a];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(int sel, bit we, logic [3:0] a, logic [7:0] wd,
                        bit exp_hit, logic [7:0] exp_rd, string req);
    int h0, m0, guard;
    while (!cpu_ready[sel]) @(negedge clk);
    last_start = log_len(sel);
    h0 = int'(hits[sel]);
    m0 = int'(misses[sel]);
    cpu_req[sel]   = 1'b1;
    cpu_we[sel]    = we;
    cpu_addr[sel]  = a;
    cpu_wdata[sel] = wd;
    @(negedge clk);
    cpu_req[sel] = 1'b0;
    check("R10 ready low while busy", 32'(cpu_ready[sel]), 32'd0);
    guard = 0;
    while (!cpu_done[sel] && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check("R10 done raised", 32'(cpu_done[sel]), 32'd1);
    if (!we) check({req, " load data"}, 32'(cpu_rdata[sel]), 32'(exp_rd));
    check({req, " R11 hit count"}, 32'(hits[sel]), 32'(exp_hit ? h0 + 1 : h0));
    check({req, " R11 miss count"}, 32'(misses[sel]), 32'(exp_hit ? m0 : m0 + 1));
    @(negedge clk);
    check("R10 done one cycle", 32'(cpu_done[sel]), 32'd0);
  endtask

  task automatic expect_log(int sel, int k, bit we, int a, logic [7:0] d, string req);
    check({req, " memory log entry"}, 32'(log_at(sel, last_start + k)),
          32'({we, 4'(a), d}));
  endtask

  task automatic expect_len(int sel, int n, string req);
    check({req, " memory transfer count"}, 32'(log_len(sel) - last_start), 32'(n));
  endtask

  task automatic t_reset;
    for (int s = 0; s < 2; s++) begin
      check("R1 ready after reset", 32'(cpu_ready[s]), 32'd1);
      check("R1 no mem request", 32'(mem_req[s]), 32'd0);
      check("R1 hit count zero", 32'(hits[s]), 32'd0);
      check("R1 miss count zero", 32'(misses[s]), 32'd0);
    end
  endtask

  task automatic t_load_fill;
    access(0, 1'b0, 4'd3, 8'h00, 1'b0, ib(3), "R2");
    expect_len(0, 2, "R2");
    expect_log(0, 0, 1'b0, 2, ib(2), "R2 offset 0 first");
    expect_log(0, 1, 1'b0, 3, ib(3), "R2 offset 1 second");
  endtask

  task automatic t_hits;
    access(0, 1'b0, 4'd2, 8'h00, 1'b1, ib(2), "R3");
    expect_len(0, 0, "R3");
  endtask

  task automatic t_assoc;
    access(0, 1'b0, 4'd14, 8'h00, 1'b0, ib(14), "R5 second block");
    access(0, 1'b0, 4'd3, 8'h00, 1'b1, ib(3), "R5 first still resident");
    access(0, 1'b0, 4'd15, 8'h00, 1'b1, ib(15), "R5 second still resident");
  endtask

  task automatic t_lru;
    access(0, 1'b0, 4'd2, 8'h00, 1'b1, ib(2), "R4 touch tag1");
    access(0, 1'b0, 4'd8, 8'h00, 1'b0, ib(8), "R4 miss evicts lru");
    expect_len(0, 2, "R7 clean victim no write");
    access(0, 1'b0, 4'd3, 8'h00, 1'b1, ib(3), "R4 mru kept");
    access(0, 1'b0, 4'd14, 8'h00, 1'b0, ib(14), "R4 lru was evicted");
  endtask

  task automatic t_wb_store;
    access(0, 1'b1, 4'd14, 8'hA5, 1'b1, 8'h00, "R6 store hit");
    expect_len(0, 0, "R6");
    check("R6 memory unchanged", 32'(mem_at(0, 14)), 32'(ib(14)));
    access(0, 1'b0, 4'd14, 8'h00, 1'b1, 8'hA5, "R6 cached value");
    access(0, 1'b1, 4'd2, 8'h5A, 1'b1, 8'h00, "R4 store touches");
  endtask

  task automatic t_wb_evict;
    access(0, 1'b0, 4'd6, 8'h00, 1'b0, ib(6), "R7 dirty evict");
    expect_len(0, 4, "R7");
    expect_log(0, 0, 1'b1, 14, 8'hA5, "R7 writeback byte 0");
    expect_log(0, 1, 1'b1, 15, ib(15), "R7 writeback byte 1");
    expect_log(0, 2, 1'b0, 6, ib(6), "R7 fill after writeback");
    expect_log(0, 3, 1'b0, 7, ib(7), "R7 fill byte 1");
  endtask

  task automatic t_store_miss;
    access(0, 1'b1, 4'd9, 8'h3C, 1'b0, 8'h00, "R8 store miss");
    expect_len(0, 4, "R8");
    expect_log(0, 0, 1'b1, 2, 8'h5A, "R4 store-made-mru victim wb0");
    expect_log(0, 1, 1'b1, 3, ib(3), "R7 victim wb1");
    expect_log(0, 2, 1'b0, 8, ib(8), "R8 allocate fill 0");
    expect_log(0, 3, 1'b0, 9, ib(9), "R8 allocate fill 1");
    check("R8 no write to memory", 32'(mem_at(0, 9)), 32'(ib(9)));
    access(0, 1'b0, 4'd9, 8'h00, 1'b1, 8'h3C, "R8 stored byte");
    access(0, 1'b0, 4'd8, 8'h00, 1'b1, ib(8), "R8 neighbour byte");
  endtask

  task automatic t_write_through;
    access(1, 1'b1, 4'd5, 8'h77, 1'b0, 8'h00, "R9 store miss");
    expect_len(1, 3, "R9");
    expect_log(1, 0, 1'b0, 4, ib(4), "R8 wt fill 0");
    expect_log(1, 1, 1'b0, 5, ib(5), "R8 wt fill 1");
    expect_log(1, 2, 1'b1, 5, 8'h77, "R9 store after fill");
    access(1, 1'b1, 4'd4, 8'h66, 1'b1, 8'h00, "R9 store hit");
    expect_len(1, 1, "R9");
    expect_log(1, 0, 1'b1, 4, 8'h66, "R9 store hit writes");
    access(1, 1'b0, 4'd4, 8'h00, 1'b1, 8'h66, "R9 cached");
    access(1, 1'b0, 4'd5, 8'h00, 1'b1, 8'h77, "R9 cached");
    access(1, 1'b0, 4'd10, 8'h00, 1'b0, ib(10), "R9 fill second");
    access(1, 1'b0, 4'd12, 8'h00, 1'b0, ib(12), "R9 evict");
    expect_len(1, 2, "R9 eviction never writes");
    access(1, 1'b0, 4'd5, 8'h00, 1'b0, 8'h77, "R9 memory holds store");
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      cpu_req[s]   = 1'b0;
      cpu_we[s]    = 1'b0;
      cpu_addr[s]  = '0;
      cpu_wdata[s] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_load_fill;
    t_hits;
    t_assoc;
    t_lru;
    t_wb_store;
    t_wb_evict;
    t_store_miss;
    t_write_through;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule